// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This controller watches two level inputs, the ignition key and the seat belt switch, and drives a reminder alarm. When the key is turned on, it opens a grace period. If the belt is still unfastened when that period ends, it raises the alarm for a bounded time. Both phases are timed by one internal counter. The counter starts when the key turns on and advances only on cycles where a clock-enable tick is high. The grace length and the alarm length are parameters counted in ticks. A 1 Hz tick with five ticks for each phase gives a 5 s grace period followed by an alarm of at most 5 s.

The controller is a Moore machine with three states: idle, waiting and alarming. The alarm output is high only while alarming. A one-cycle timer-start pulse marks each entry into the waiting state. Fastening the belt or turning the key off ends the waiting or alarming phase early. After the controller returns to idle for any reason other than the key going off, it stays idle until the key is cycled off and then on again. The inputs are expected to be debounced and synchronous to the clock.

Top module: `seatbelt_alarm`

## Requirements
- R1: After reset the controller is idle, with `alarm` low and `timer_start` low.
- R2: A low-to-high change of `key_on` seen while idle moves the controller to waiting. It raises `timer_start` for exactly one cycle, beginning at the same edge, and restarts the tick count from zero.
- R3: While waiting with the key on and the belt unfastened, `alarm` rises at the clock edge that samples the GRACE_TICKS-th tick counted from entry, and not before.
- R4: With no early exit, `alarm` stays high through the next ALARM_TICKS-1 ticks. It falls at the edge that samples the (GRACE_TICKS+ALARM_TICKS)-th tick counted from entry.
- R5: `belt_on` high while waiting returns the controller to idle at the next edge, and no alarm follows.
- R6: `key_on` low while waiting returns the controller to idle at the next edge, and no alarm follows.
- R7: While alarming, `belt_on` high or `key_on` low drops `alarm` at the next edge.
- R8: Once idle with the key still on, the controller neither pulses `timer_start` nor raises `alarm`, whatever ticks or belt changes occur. Only a new off-to-on change of the key arms it again.
- R9: Only cycles with `tick` high advance the count. Idle cycles between ticks do not shift when the alarm rises or falls, and ticks received while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable for the phase timer, one cycle per time unit |
| key_on | input | 1 | Ignition key level, high when on |
| belt_on | input | 1 | Seat belt level, high when fastened |
| alarm | output | 1 | Reminder alarm level |
| timer_start | output | 1 | One-cycle pulse when the timed sequence starts |

## Verification
The full sequence is first run with a different number of idle cycles between successive ticks. This shows that alarm onset and release depend on the tick count alone and not on elapsed clock cycles. Early exits are then swept over every tick position: a belt fastening and a key removal at each point of the grace period, and both at each point of the alarm. These sweeps separate a controller that honours an exit at every count from one that ignores it near a phase boundary. Each early exit, and the natural timeout, is followed by further ticks with the key held on. This tells a controller that correctly stays idle apart from one that rearms by itself.

// File: rtl/seatbelt_alarm.sv
module seatbelt_alarm #(
  parameter int GRACE_TICKS = 5,
  parameter int ALARM_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic key_on,
  input  logic belt_on,
  output logic alarm,
  output logic timer_start
);
  localparam int TOTAL = GRACE_TICKS + ALARM_TICKS;
  localparam int CW = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {S_OFF, S_WAIT, S_ALARM} state_t;

  state_t        state, state_nx;
  logic          key_q;
  logic [CW-1:0] cnt;

  wire key_rise  = key_on & ~key_q;
  wire grace_end = tick && (cnt == CW'(GRACE_TICKS - 1));
  wire alarm_end = tick && (cnt == CW'(TOTAL - 1));

  always_comb begin
    state_nx = state;
    case (state)
      S_OFF:   if (key_rise) state_nx = S_WAIT;
      S_WAIT:  if (!key_on || belt_on) state_nx = S_OFF;
               else if (grace_end) state_nx = S_ALARM;
      S_ALARM: if (!key_on || belt_on || alarm_end) state_nx = S_OFF;
      default: state_nx = S_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_OFF;
      key_q       <= 1'b0;
      cnt         <= '0;
      timer_start <= 1'b0;
    end else begin
      state       <= state_nx;
      key_q       <= key_on;
      timer_start <= (state == S_OFF) && (state_nx == S_WAIT);
      if (state == S_OFF) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
    end
  end

  assign alarm = (state == S_ALARM);

  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TOTAL));
  a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start |=> !timer_start);
  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timer_start |-> ($past(state) == S_OFF) && $past(key_on) && !alarm);
  a_r3_alarm_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(tick) && ($past(state) == S_WAIT));
  a_r7_belt_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && belt_on) |=> !alarm);
  a_r7_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !key_on) |=> !alarm);
  a_r9_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !tick && key_on && !belt_on) |=> (state == S_WAIT) && !alarm);
  a_r8_no_self_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF && key_q && key_on) |=> !timer_start);
endmodule

// File: tb/test_seatbelt_alarm.sv
module test_seatbelt_alarm;
  localparam int G = 4;
  localparam int A = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic key_on = 1'b0;
  logic belt_on = 1'b0;
  logic alarm, timer_start;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seatbelt_alarm #(.GRACE_TICKS(G), .ALARM_TICKS(A)) i_seatbelt_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on), .belt_on(belt_on),
    .alarm(alarm), .timer_start(timer_start));

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic t);
    tick = t;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic arm();
    key_on = 1'b0; belt_on = 1'b0;
    step(1'b0);
    key_on = 1'b1;
    step(1'b0);
    chk("R2 start pulse", timer_start, 1'b1);
    chk("R2 alarm at start", alarm, 1'b0);
    step(1'b0);
    chk("R2 pulse one cycle", timer_start, 1'b0);
  endtask

  task automatic stay_quiet(input string req);
    for (int i = 0; i < G + A + 2; i++) begin
      step(1'b1);
      chk(req, alarm, 1'b0);
      chk(req, timer_start, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 alarm reset", alarm, 1'b0);
    chk("R1 start reset", timer_start, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < G + 2; i++) begin
      step(1'b1);
      chk("R9 ticks while idle", alarm, 1'b0);
    end
    arm();
    for (int k = 1; k <= G; k++) begin
      for (int g = 0; g < k; g++) begin
        step(1'b0);
        chk("R9 idle cycles do not count", alarm, 1'b0);
      end
      step(1'b1);
      chk("R3 grace end", alarm, (k == G));
    end
    for (int k = 1; k <= A; k++) begin
      step(1'b0);
      chk("R9 alarm held between ticks", alarm, 1'b1);
      step(1'b1);
      chk("R4 alarm length", alarm, (k < A));
    end
    stay_quiet("R8 no rearm after timeout");
    belt_on = 1'b1; step(1'b0); belt_on = 1'b0;
    stay_quiet("R8 belt toggle no rearm");

    for (int k = 0; k < G; k++) begin
      arm();
      for (int i = 0; i < k; i++) step(1'b1);
      belt_on = 1'b1;
      step(1'b0);
      belt_on = 1'b0;
      stay_quiet("R5 belt in wait");
    end

    for (int k = 0; k < G; k++) begin
      arm();
      for (int i = 0; i < k; i++) step(1'b1);
      key_on = 1'b0;
      step(1'b0);
      stay_quiet("R6 key off in wait");
    end

    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < A; j++) begin
        arm();
        for (int i = 0; i < G; i++) step(1'b1);
        chk("R3 alarm raised", alarm, 1'b1);
        for (int i = 0; i < j; i++) step(1'b1);
        chk("R4 alarm still on", alarm, 1'b1);
        if (m == 0) belt_on = 1'b1; else key_on = 1'b0;
        step(1'b0);
        chk(m == 0 ? "R7 belt in alarm" : "R7 key off in alarm", alarm, 1'b0);
        belt_on = 1'b0;
        stay_quiet("R8 quiet after early exit");
      end
    end

    arm();
    for (int i = 0; i < G; i++) step(1'b1);
    chk("R2 rearm after key cycle", alarm, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule